// File: doc/BRIEF.md
# Clock Frequency Source Select Controller

This block is the control logic of a programmable clock generator. It decides which divider setting drives the CPU clock synthesizer. Three sources compete. The first is the latched strap code read at power-up. The second is a software-programmed N/M feedback pair. The third is a recovery N/M pair that takes over by itself when a watchdog timeout pulse arrives. A separate override bit chooses where the CPU/SDRAM/PCI ratio code comes from. This choice is independent of the frequency source: the ratio comes either from the strap code or from a software ratio register.

Software reaches the block through a simple byte-wide write port (address, data, strobe). The block presents registered outputs to the synthesizer:
- the active N and M values,
- a flag telling whether N/M or the strap table is in use,
- the ratio code,
- a one-cycle load strobe that marks every effective change of these values.

Programmed values reach the synthesizer only when their M byte is written. Recovery values are live, so writing either of their bytes takes effect at once.

Top module: `clk_src_ctrl`

## Requirements
- R1: While reset is high (synchronous, active high), all registers clear to 0, including the recovery N/M, the recovery select and the programmed N/M. The outputs read use_nm=0, syn_n=0, syn_m=0, ratio_code=0 and syn_load=0.
- R2: The write port decodes six addresses:
  - 0 is control: bit0 enables programmed mode, bit1 enables ratio override.
  - 1 is the ratio register, bits 4:0.
  - 2 is the recovery N byte.
  - 3 holds recovery M in bits 6:0 and the recovery select in bit 7.
  - 4 is the programmed N byte.
  - 5 is the programmed M, bits 6:0.
- R3: With no timeout seen and programmed mode off, use_nm is 0 and syn_n and syn_m read 0 (the strap table is in use).
- R4: With the override bit clear, ratio_code follows the latched strap code. With it set, ratio_code follows the ratio register.
- R5: In programmed mode (no timeout seen), syn_n/syn_m show the pair captured at the last write to address 5. That write captures the programmed N byte together with the new M. Writing address 4 alone leaves the outputs unchanged.
- R6: A timeout pulse puts the block in recovery, which stays in force until reset. Recovery takes priority over programmed mode.
- R7: In recovery with select 0, the strap table is used (use_nm=0). With select 1, syn_n/syn_m follow the recovery bytes directly, so a write to only one of them applies a mixed pair.
- R8: syn_load is high for exactly the cycles in which {use_nm, syn_n, syn_m, ratio_code} took a value different from the cycle before. Otherwise it is low.
- R9: A write, timeout pulse or strap change that is sampled on one rising edge shows on the outputs (with syn_load) after the next rising edge, not earlier.
- R10: Writes to addresses 6 and above change nothing. Bit 7 of the programmed M write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register address |
| wr_data | input | 8 | Register write data |
| strap_fs | input | CODE_W (5) | Latched strap frequency code |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| syn_n | output | N_W (8) | Active N feedback value |
| syn_m | output | M_W (7) | Active M feedback value |
| use_nm | output | 1 | 1 = N/M in use, 0 = strap table in use |
| ratio_code | output | CODE_W (5) | Active ratio code |
| syn_load | output | 1 | One-cycle synthesizer load strobe |

## Verification
The hardest case to reach is a mixed recovery pair. It needs a timeout pulse first, then a write that sets the recovery select, and then a write to only the other recovery byte while programmed mode is still enabled underneath. The stimulus builds this up in that order. It then clears programmed mode and pulses the watchdog again to show that recovery holds. A behavioural model in the bench follows every cycle, so each of these steps and every silent write are compared on the load strobe as well as on the values.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_SEL  = 1;
  localparam int unsigned A_RN   = 2;
  localparam int unsigned A_RM   = 3;
  localparam int unsigned A_PN   = 4;
  localparam int unsigned A_PM   = 5;
  typedef enum logic [1:0] {SRC_STRAP, SRC_PROG, SRC_RECOV} src_e;
endpackage

// File: rtl/csc_regfile.sv
module csc_regfile
  import clk_src_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CODE_W-1:0] strap_fs,
  input  logic              wdt_expire,
  output logic              prog_en,
  output logic              ratio_ovr,
  output logic [CODE_W-1:0] sel_code,
  output logic [N_W-1:0]    rec_n,
  output logic [M_W-1:0]    rec_m,
  output logic              rec_sel,
  output logic [N_W-1:0]    prog_n,
  output logic [N_W-1:0]    pld_n,
  output logic [M_W-1:0]    pld_m,
  output logic              rec_active,
  output logic [CODE_W-1:0] strap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_en    <= 1'b0;
      ratio_ovr  <= 1'b0;
      sel_code   <= '0;
      rec_n      <= '0;
      rec_m      <= '0;
      rec_sel    <= 1'b0;
      prog_n     <= '0;
      pld_n      <= '0;
      pld_m      <= '0;
      rec_active <= 1'b0;
      strap_q    <= '0;
    end else begin
      strap_q <= strap_fs;
      if (wdt_expire) rec_active <= 1'b1;
      if (wr_en) begin
        case (wr_addr)
          ADDR_W'(A_CTRL): begin
            prog_en   <= wr_data[0];
            ratio_ovr <= wr_data[1];
          end
          ADDR_W'(A_SEL): sel_code <= wr_data[CODE_W-1:0];
          ADDR_W'(A_RN):  rec_n    <= wr_data[N_W-1:0];
          ADDR_W'(A_RM): begin
            rec_m   <= wr_data[M_W-1:0];
            rec_sel <= wr_data[DATA_W-1];
          end
          ADDR_W'(A_PN):  prog_n   <= wr_data[N_W-1:0];
          ADDR_W'(A_PM): begin
            pld_m <= wr_data[M_W-1:0];
            pld_n <= prog_n;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/csc_src_select.sv
module csc_src_select
  import clk_src_pkg::*;
#(
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int CODE_W = 5
) (
  input  logic              prog_en,
  input  logic              ratio_ovr,
  input  logic [CODE_W-1:0] sel_code,
  input  logic [N_W-1:0]    rec_n,
  input  logic [M_W-1:0]    rec_m,
  input  logic              rec_sel,
  input  logic [N_W-1:0]    pld_n,
  input  logic [M_W-1:0]    pld_m,
  input  logic              rec_active,
  input  logic [CODE_W-1:0] strap_q,
  output logic              nx_use,
  output logic [N_W-1:0]    nx_n,
  output logic [M_W-1:0]    nx_m,
  output logic [CODE_W-1:0] nx_ratio
);
  src_e src;

  always_comb begin
    if (rec_active)   src = SRC_RECOV;
    else if (prog_en) src = SRC_PROG;
    else              src = SRC_STRAP;
  end

  always_comb begin
    nx_use = 1'b0;
    nx_n   = '0;
    nx_m   = '0;
    case (src)
      SRC_RECOV: if (rec_sel) begin
        nx_use = 1'b1;
        nx_n   = rec_n;
        nx_m   = rec_m;
      end
      SRC_PROG: begin
        nx_use = 1'b1;
        nx_n   = pld_n;
        nx_m   = pld_m;
      end
      default: ;
    endcase
    nx_ratio = ratio_ovr ? sel_code : strap_q;
  end
endmodule

// File: rtl/csc_out_stage.sv
module csc_out_stage #(
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nx_use,
  input  logic [N_W-1:0]    nx_n,
  input  logic [M_W-1:0]    nx_m,
  input  logic [CODE_W-1:0] nx_ratio,
  output logic              use_nm,
  output logic [N_W-1:0]    syn_n,
  output logic [M_W-1:0]    syn_m,
  output logic [CODE_W-1:0] ratio_code,
  output logic              syn_load
);
  localparam int VEC_W = 1 + N_W + M_W + CODE_W;
  logic [VEC_W-1:0] nx_vec, cur_vec;

  assign nx_vec  = {nx_use, nx_n, nx_m, nx_ratio};
  assign cur_vec = {use_nm, syn_n, syn_m, ratio_code};

  always_ff @(posedge clk) begin
    if (rst) begin
      use_nm     <= 1'b0;
      syn_n      <= '0;
      syn_m      <= '0;
      ratio_code <= '0;
      syn_load   <= 1'b0;
    end else begin
      use_nm     <= nx_use;
      syn_n      <= nx_n;
      syn_m      <= nx_m;
      ratio_code <= nx_ratio;
      syn_load   <= (nx_vec != cur_vec);
    end
  end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [CODE_W-1:0] strap_fs,
  input  logic              wdt_expire,
  output logic [N_W-1:0]    syn_n,
  output logic [M_W-1:0]    syn_m,
  output logic              use_nm,
  output logic [CODE_W-1:0] ratio_code,
  output logic              syn_load
);
  logic              prog_en, ratio_ovr, rec_sel, rec_active;
  logic [CODE_W-1:0] sel_code, strap_q;
  logic [N_W-1:0]    rec_n, prog_n, pld_n;
  logic [M_W-1:0]    rec_m, pld_m;
  logic              nx_use;
  logic [N_W-1:0]    nx_n;
  logic [M_W-1:0]    nx_m;
  logic [CODE_W-1:0] nx_ratio;

  csc_regfile #(.ADDR_W(ADDR_W), .N_W(N_W), .M_W(M_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .strap_fs(strap_fs), .wdt_expire(wdt_expire), .prog_en(prog_en),
    .ratio_ovr(ratio_ovr), .sel_code(sel_code), .rec_n(rec_n), .rec_m(rec_m),
    .rec_sel(rec_sel), .prog_n(prog_n), .pld_n(pld_n), .pld_m(pld_m),
    .rec_active(rec_active), .strap_q(strap_q)
  );

  csc_src_select #(.N_W(N_W), .M_W(M_W), .CODE_W(CODE_W)) u_sel (
    .prog_en(prog_en), .ratio_ovr(ratio_ovr), .sel_code(sel_code),
    .rec_n(rec_n), .rec_m(rec_m), .rec_sel(rec_sel), .pld_n(pld_n),
    .pld_m(pld_m), .rec_active(rec_active), .strap_q(strap_q),
    .nx_use(nx_use), .nx_n(nx_n), .nx_m(nx_m), .nx_ratio(nx_ratio)
  );

  csc_out_stage #(.N_W(N_W), .M_W(M_W), .CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst), .nx_use(nx_use), .nx_n(nx_n), .nx_m(nx_m),
    .nx_ratio(nx_ratio), .use_nm(use_nm), .syn_n(syn_n), .syn_m(syn_m),
    .ratio_code(ratio_code), .syn_load(syn_load)
  );
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wdt_expire,
  input logic              rec_active,
  input logic              use_nm,
  input logic [N_W-1:0]    syn_n,
  input logic [M_W-1:0]    syn_m,
  input logic [CODE_W-1:0] ratio_code,
  input logic              syn_load
);
  logic pv = 1'b0;
  always_ff @(posedge clk) pv <= !rst;

  // R8: strobe marks exactly the cycles whose output vector changed
  p_load_on_change_r8: assert property (@(posedge clk) disable iff (rst)
    pv |-> (syn_load == ({use_nm, syn_n, syn_m, ratio_code} !=
                         $past({use_nm, syn_n, syn_m, ratio_code}))));

  // R6: a timeout pulse enters recovery
  p_wdt_enters_rec_r6: assert property (@(posedge clk) disable iff (rst)
    wdt_expire |=> rec_active);

  // R6: recovery holds until reset
  p_rec_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    rec_active |=> rec_active);

  // R3: strap table in use means no N/M presented
  p_nm_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !use_nm |-> (syn_n == '0 && syn_m == '0));
endmodule

bind clk_src_ctrl csc_checker #(.N_W(N_W), .M_W(M_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .wdt_expire(wdt_expire), .rec_active(rec_active),
  .use_nm(use_nm), .syn_n(syn_n), .syn_m(syn_m), .ratio_code(ratio_code),
  .syn_load(syn_load)
);

// File: tb/clk_src_ctrl_tb.sv
module clk_src_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] strap_fs = 5'h0B;
  logic       wdt_expire = 1'b0;
  logic [7:0] syn_n;
  logic [6:0] syn_m;
  logic       use_nm;
  logic [4:0] ratio_code;
  logic       syn_load;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_src_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .strap_fs(strap_fs), .wdt_expire(wdt_expire), .syn_n(syn_n), .syn_m(syn_m),
    .use_nm(use_nm), .ratio_code(ratio_code), .syn_load(syn_load)
  );

  // behavioural reference model
  bit       m_pen, m_ovr, m_rsel, m_rec;
  int       m_sel, m_rn, m_rm, m_pn, m_ln, m_lm, m_strap;
  int       e_use, e_n, e_m, e_ratio;
  bit       e_load;

  always @(posedge clk) begin
    if (rst) begin
      m_pen = 0; m_ovr = 0; m_rsel = 0; m_rec = 0;
      m_sel = 0; m_rn = 0; m_rm = 0; m_pn = 0; m_ln = 0; m_lm = 0; m_strap = 0;
      e_use = 0; e_n = 0; e_m = 0; e_ratio = 0; e_load = 0;
    end else begin
      int u, n, m, r;
      u = 0; n = 0; m = 0;
      if (m_rec) begin
        if (m_rsel) begin u = 1; n = m_rn; m = m_rm; end
      end else if (m_pen) begin
        u = 1; n = m_ln; m = m_lm;
      end
      r = m_ovr ? m_sel : m_strap;
      e_load = (u != e_use) || (n != e_n) || (m != e_m) || (r != e_ratio);
      e_use = u; e_n = n; e_m = m; e_ratio = r;
      m_strap = strap_fs;
      if (wdt_expire) m_rec = 1;
      if (wr_en) begin
        if (wr_addr == 0) begin m_pen = wr_data[0]; m_ovr = wr_data[1]; end
        else if (wr_addr == 1) m_sel = wr_data % 32;
        else if (wr_addr == 2) m_rn = wr_data;
        else if (wr_addr == 3) begin m_rm = wr_data % 128; m_rsel = wr_data[7]; end
        else if (wr_addr == 4) m_pn = wr_data;
        else if (wr_addr == 5) begin m_lm = wr_data % 128; m_ln = m_pn; end
      end
    end
  end

  string phase = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk(use_nm == e_use[0], {phase, " use_nm"}, use_nm, e_use);
      chk(syn_n == e_n[7:0], {phase, " syn_n"}, syn_n, e_n);
      chk(syn_m == e_m[6:0], {phase, " syn_m"}, syn_m, e_m);
      chk(ratio_code == e_ratio[4:0], {phase, " ratio"}, ratio_code, e_ratio);
      chk(syn_load == e_load, "R8 syn_load vs model", syn_load, e_load);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wdt_pulse();
    @(negedge clk); wdt_expire = 1'b1;
    @(negedge clk); wdt_expire = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input int u, input int n, input int m,
                            input int r, input int ld);
    chk(use_nm == u[0], req, use_nm, u);
    chk(syn_n == n[7:0], req, syn_n, n);
    chk(syn_m == m[6:0], req, syn_m, m);
    chk(ratio_code == r[4:0], req, ratio_code, r);
    chk(syn_load == ld[0], req, syn_load, ld);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    // R1: reset state
    idle(3);
    expect_out("R1 reset", 0, 0, 0, 0, 0);
    rst = 1'b0;
    idle(3);
    phase = "R3";
    expect_out("R3 strap default", 0, 0, 0, 5'h0B, 0);

    // R4 / R2: ratio override from ratio register
    phase = "R4";
    wr(1, 8'h13);
    wr(0, 8'h02);
    @(negedge clk);
    expect_out("R4 override on", 0, 0, 0, 5'h13, 1);
    wr(0, 8'h00);
    @(negedge clk);
    expect_out("R4 override off", 0, 0, 0, 5'h0B, 1);

    // R5: programmed mode, M write loads the pair
    phase = "R5";
    wr(4, 8'h55);
    wr(0, 8'h01);
    @(negedge clk);
    expect_out("R5 enable before load", 1, 0, 0, 5'h0B, 1);
    wr(4, 8'h77);
    @(negedge clk);
    expect_out("R5 N alone no effect", 1, 0, 0, 5'h0B, 0);
    wr(5, 8'h2A);
    @(negedge clk);
    expect_out("R5 M write loads", 1, 8'h77, 8'h2A, 5'h0B, 1);

    // R10: ignored bit and unmapped address
    phase = "R10";
    wr(5, 8'hAA);
    @(negedge clk);
    expect_out("R10 prog M bit7 ignored", 1, 8'h77, 8'h2A, 5'h0B, 0);
    wr(4'hA, 8'hFF);
    idle(2);
    expect_out("R10 unmapped write", 1, 8'h77, 8'h2A, 5'h0B, 0);

    // R6 / R7: timeout with recovery select 0 falls back to strap table
    phase = "R6";
    wdt_pulse();
    @(negedge clk);
    expect_out("R6 R7 timeout select 0", 0, 0, 0, 5'h0B, 1);

    // R7 / R9: recovery select 1, live bytes, mixed pair
    phase = "R7";
    wr(3, 8'h90);
    expect_out("R9 not yet visible", 0, 0, 0, 5'h0B, 0);
    @(negedge clk);
    expect_out("R7 recovery M live", 1, 0, 8'h10, 5'h0B, 1);
    wr(2, 8'h44);
    @(negedge clk);
    expect_out("R7 mixed pair", 1, 8'h44, 8'h10, 5'h0B, 1);

    // R6: recovery sticky and over programmed mode
    phase = "R6";
    wr(0, 8'h00);
    idle(2);
    expect_out("R6 prog off no effect", 1, 8'h44, 8'h10, 5'h0B, 0);
    wdt_pulse();
    idle(2);
    expect_out("R6 second timeout", 1, 8'h44, 8'h10, 5'h0B, 0);

    // R9: strap change latency
    phase = "R9";
    @(negedge clk); strap_fs = 5'h1C;
    @(negedge clk);
    expect_out("R9 one edge", 1, 8'h44, 8'h10, 5'h0B, 0);
    @(negedge clk);
    expect_out("R9 two edges", 1, 8'h44, 8'h10, 5'h1C, 1);

    // R1 / R6: reset clears recovery
    phase = "R1";
    @(negedge clk); rst = 1'b1;
    idle(2);
    expect_out("R1 reset again", 0, 0, 0, 0, 0);
    rst = 1'b0;
    idle(3);
    phase = "R6";
    expect_out("R6 cleared by reset", 0, 0, 0, 5'h1C, 0);

    idle(2);
    finish_run();
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule